// File: doc/BRIEF.md
# Debug Event Monitor

This block sits beside a processor's retirement stage and watches each retiring instruction for four kinds of debug event. The four kinds are a taken branch, a write to one of a chosen set of general registers, an instruction fetched from a watched address region, and a store that touches that region. Software loads a control word and two region bounds through a small write port. The processor's status logic supplies two level signals: the extended-mode flag and the global monitor mask.

When a retiring instruction triggers at least one event type that is enabled, and both status gates are open, the block raises an interrupt request. One cycle after the instruction retires, it presents a one-hot-per-type event vector and the instruction's address. The request and its captured values stay in place until the handler acknowledges them. An event that arrives while a gate is closed, or while an earlier request is still waiting, is lost. It is never reported later.

Top module: `dbg_evt_mon`

## Requirements
- R1: After synchronous reset, irq_req is 0 and the control word is all zeros, so every event type is disabled. Whenever no request is pending, irq_code and irq_addr read 0.
- R2: A write with cfg_we=1 updates one register on the next clock edge, chosen by cfg_sel. The values are 0 for the control word, 1 for the region start and 2 for the region end. cfg_sel=3 changes nothing. Control word bit 0 enables branch events, bit 1 register events, bit 2 fetch events and bit 3 store events. Bits 4+n select general register n for n=0..15.
- R3: A retiring instruction with ret_branch=1 is a branch event. It is irq_code bit 0.
- R4: A retiring instruction with ret_gpr_we=1 is a register event when the control-word bit for register ret_gpr_idx is set. It is irq_code bit 1.
- R5: A retiring instruction whose ret_pc lies in the watched region is a fetch event, irq_code bit 2. A hit needs start <= address <= end, with both bounds included. When start > end, the region wraps past the top of the address space.
- R6: A store (ret_st_valid=1) covers bytes ret_st_addr through ret_st_addr+ret_st_len, counted modulo the address space, where ret_st_len is the byte count minus one. It is a store event, irq_code bit 3, when any of those bytes lies in the watched region.
- R7: An event is reported only when stat_ext=1, stat_mon=1 and its own enable bit is set. Events gated off are dropped and never appear later.
- R8: The request rises one cycle after the retiring instruction. irq_code has one bit set for every enabled event type that the instruction triggered, and irq_addr is that instruction's ret_pc.
- R9: While a request is pending and not acknowledged, irq_code and irq_addr hold, and new events are discarded. In a cycle with irq_ack=1 the request clears, unless that same cycle retires an instruction with enabled events, which is captured instead.
- R10: With ret_valid=0 no event is recognised, whatever the other retirement inputs say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 start, 2 end, 3 none |
| cfg_wdata | input | max(AW,20) | Write data |
| stat_ext | input | 1 | Extended-mode flag from the status word |
| stat_mon | input | 1 | Global monitor mask from the status word |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | AW | Address of the retiring instruction |
| ret_branch | input | 1 | Instruction is a taken branch |
| ret_gpr_we | input | 1 | Instruction writes a general register |
| ret_gpr_idx | input | 4 | Index of the written register |
| ret_st_valid | input | 1 | Instruction stores to memory |
| ret_st_addr | input | AW | First byte address of the store |
| ret_st_len | input | log2(MAXB) | Store byte count minus one |
| irq_ack | input | 1 | Handler acknowledge |
| irq_req | output | 1 | Interrupt request |
| irq_code | output | 4 | Captured event vector |
| irq_addr | output | AW | Captured instruction address |

## Verification
The bench builds the block with AW=8 and MAXB=4. With that setting it can sweep every instruction address and every store start and length against several regions, including a wrapped region and one that is a single byte. It also sweeps all 16 register indices against a sparse mask. It tries every combination of the four enable bits with the two status gates, and it drives the pending-request and acknowledge-collision orderings one at a time.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;

    localparam int NEVT  = 4;
    localparam int NGPR  = 16;
    localparam int GIW   = $clog2(NGPR);
    localparam int CTRLW = NEVT + NGPR;

    // bit positions inside the event vector and the enable field
    localparam int EV_BR    = 0;
    localparam int EV_GPR   = 1;
    localparam int EV_FETCH = 2;
    localparam int EV_STORE = 3;

    typedef logic [NEVT-1:0] evt_t;

    // control word: register select above, per-type enables in the low bits
    typedef struct packed {
        logic [NGPR-1:0] gmask;
        evt_t            en;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_START = 2'd1,
        SEL_END   = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    function automatic ctrl_t word_to_ctrl(input logic [CTRLW-1:0] w);
        return ctrl_t'(w);
    endfunction

endpackage

// File: rtl/dbg_evt_cfg.sv
module dbg_evt_cfg
    import dbg_evt_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] wdata,
    output ctrl_t         ctrl,
    output logic [AW-1:0] lo,
    output logic [AW-1:0] hi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            lo   <= '0;
            hi   <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_CTRL:  ctrl <= word_to_ctrl(wdata[CTRLW-1:0]);
                SEL_START: lo   <= wdata[AW-1:0];
                SEL_END:   hi   <= wdata[AW-1:0];
                default: ;
            endcase
        end
    end

    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
        we && sel == SEL_CTRL |=> ctrl == ctrl_t'($past(wdata[CTRLW-1:0])));

    // R2
    sel_none_chk: assert property (@(posedge clk) disable iff (rst)
        we && sel == SEL_NONE |=> $stable(ctrl) && $stable(lo) && $stable(hi));

endmodule

// File: rtl/dbg_evt_range.sv
module dbg_evt_range #(
    parameter int AW = 24
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic          hit
);

    logic wrap;

    always_comb begin
        wrap = lo > hi;
        if (wrap) hit = (addr >= lo) || (addr <= hi);
        else      hit = (addr >= lo) && (addr <= hi);
    end

endmodule

// File: rtl/dbg_evt_span.sv
module dbg_evt_span #(
    parameter int AW   = 24,
    parameter int MAXB = 8,
    parameter int LW   = 3
) (
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] len,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic          hit
);

    logic [MAXB-1:0] byte_hit;

    // one comparator per byte lane; lanes beyond the length are masked
    for (genvar k = 0; k < MAXB; k++) begin : g_lane
        logic [AW-1:0] baddr;
        logic          bh;
        assign baddr = base + AW'(k);
        dbg_evt_range #(.AW(AW)) u_cmp (
            .addr (baddr),
            .lo   (lo),
            .hi   (hi),
            .hit  (bh)
        );
        assign byte_hit[k] = bh && (k <= int'(len));
    end

    assign hit = |byte_hit;

endmodule

// File: rtl/dbg_evt_detect.sv
module dbg_evt_detect
    import dbg_evt_pkg::*;
(
    input  ctrl_t          ctrl,
    input  logic           stat_ext,
    input  logic           stat_mon,
    input  logic           ret_valid,
    input  logic           ret_branch,
    input  logic           ret_gpr_we,
    input  logic [GIW-1:0] ret_gpr_idx,
    input  logic           fetch_hit,
    input  logic           ret_st_valid,
    input  logic           store_hit,
    output evt_t           evt
);

    evt_t raw;
    logic armed;

    always_comb begin
        raw           = '0;
        raw[EV_BR]    = ret_branch;
        raw[EV_GPR]   = ret_gpr_we && ctrl.gmask[ret_gpr_idx];
        raw[EV_FETCH] = fetch_hit;
        raw[EV_STORE] = ret_st_valid && store_hit;
        armed         = stat_ext && stat_mon;
        evt           = (ret_valid && armed) ? (raw & ctrl.en) : '0;
    end

endmodule

// File: rtl/dbg_evt_hold.sv
module dbg_evt_hold
    import dbg_evt_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  evt_t          evt,
    input  logic [AW-1:0] pc,
    input  logic          ack,
    output logic          req,
    output evt_t          code,
    output logic [AW-1:0] addr
);

    logic take;

    assign take = !req || ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            req  <= 1'b0;
            code <= '0;
            addr <= '0;
        end else if (take) begin
            req  <= |evt;
            code <= evt;
            addr <= (|evt) ? pc : '0;
        end
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        req && !ack |=> req && $stable(code) && $stable(addr));

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        req && ack && evt == '0 |=> !req);

    // R8
    code_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        req |-> code != '0);

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !req |-> code == '0 && addr == '0);

endmodule

// File: rtl/dbg_evt_mon.sv
module dbg_evt_mon
    import dbg_evt_pkg::*;
#(
    parameter  int AW   = 24,
    parameter  int MAXB = 8,
    localparam int DW   = (AW > CTRLW) ? AW : CTRLW,
    localparam int LW   = (MAXB > 1) ? $clog2(MAXB) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic            stat_ext,
    input  logic            stat_mon,
    input  logic            ret_valid,
    input  logic [AW-1:0]   ret_pc,
    input  logic            ret_branch,
    input  logic            ret_gpr_we,
    input  logic [GIW-1:0]  ret_gpr_idx,
    input  logic            ret_st_valid,
    input  logic [AW-1:0]   ret_st_addr,
    input  logic [LW-1:0]   ret_st_len,
    input  logic            irq_ack,
    output logic            irq_req,
    output logic [NEVT-1:0] irq_code,
    output logic [AW-1:0]   irq_addr
);

    ctrl_t         ctrl;
    logic [AW-1:0] reg_lo;
    logic [AW-1:0] reg_hi;
    logic          fetch_hit;
    logic          store_hit;
    evt_t          evt;
    evt_t          code_q;

    dbg_evt_cfg #(.AW(AW), .DW(DW)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .ctrl  (ctrl),
        .lo    (reg_lo),
        .hi    (reg_hi)
    );

    dbg_evt_range #(.AW(AW)) u_fetch (
        .addr (ret_pc),
        .lo   (reg_lo),
        .hi   (reg_hi),
        .hit  (fetch_hit)
    );

    dbg_evt_span #(.AW(AW), .MAXB(MAXB), .LW(LW)) u_store (
        .base (ret_st_addr),
        .len  (ret_st_len),
        .lo   (reg_lo),
        .hi   (reg_hi),
        .hit  (store_hit)
    );

    dbg_evt_detect u_det (
        .ctrl         (ctrl),
        .stat_ext     (stat_ext),
        .stat_mon     (stat_mon),
        .ret_valid    (ret_valid),
        .ret_branch   (ret_branch),
        .ret_gpr_we   (ret_gpr_we),
        .ret_gpr_idx  (ret_gpr_idx),
        .fetch_hit    (fetch_hit),
        .ret_st_valid (ret_st_valid),
        .store_hit    (store_hit),
        .evt          (evt)
    );

    dbg_evt_hold #(.AW(AW)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .pc   (ret_pc),
        .ack  (irq_ack),
        .req  (irq_req),
        .code (code_q),
        .addr (irq_addr)
    );

    assign irq_code = code_q;

    // R7
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_req && !(stat_ext && stat_mon) |=> !irq_req);

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_req && evt != '0 |=> irq_req && irq_code == $past(evt)
                                   && irq_addr == $past(ret_pc));

    // R10
    no_retire_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_req && !ret_valid |=> !irq_req);

endmodule

// File: tb/sim_dbg_evt_mon.sv
`timescale 1ns/1ps
module sim_dbg_evt_mon;

    localparam int AW = 8;
    localparam int MAXB = 4;
    localparam int DW = 20;
    localparam int LW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic stat_ext = 1'b0, stat_mon = 1'b0;
    logic ret_valid = 1'b0, ret_branch = 1'b0, ret_gpr_we = 1'b0, ret_st_valid = 1'b0;
    logic [AW-1:0] ret_pc = '0, ret_st_addr = '0;
    logic [3:0] ret_gpr_idx = '0;
    logic [LW-1:0] ret_st_len = '0;
    logic irq_ack = 1'b0;
    logic irq_req;
    logic [3:0] irq_code;
    logic [AW-1:0] irq_addr;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench copy of the configuration
    logic [3:0]  b_en = '0;
    logic [15:0] b_mask = '0;
    logic [7:0]  b_lo = '0, b_hi = '0;

    always #4 clk = ~clk;

    dbg_evt_mon #(.AW(AW), .MAXB(MAXB)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .stat_ext(stat_ext), .stat_mon(stat_mon), .ret_valid(ret_valid), .ret_pc(ret_pc),
        .ret_branch(ret_branch), .ret_gpr_we(ret_gpr_we), .ret_gpr_idx(ret_gpr_idx),
        .ret_st_valid(ret_st_valid), .ret_st_addr(ret_st_addr), .ret_st_len(ret_st_len),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_code(irq_code), .irq_addr(irq_addr)
    );

    // distance from start modulo 256, compared with region length
    function automatic bit in_reg(logic [7:0] a);
        logic [7:0] d, span;
        d = a - b_lo;
        span = b_hi - b_lo;
        return d <= span;
    endfunction

    function automatic logic [3:0] model(bit v, logic [7:0] pc, bit br, bit gwe,
                                         logic [3:0] gi, bit sv, logic [7:0] sa,
                                         int sl);
        logic [3:0] r;
        r = '0;
        if (!v || !stat_ext || !stat_mon) return '0;
        r[0] = br;
        r[1] = gwe && b_mask[gi];
        r[2] = in_reg(pc);
        if (sv)
            for (int k = 0; k <= sl; k++)
                if (in_reg(8'(sa + k))) r[3] = 1'b1;
        return r & b_en;
    endfunction

    task automatic chk(string tag, bit er, logic [3:0] ec, logic [7:0] ea);
        n_chk++;
        if (irq_req !== er || irq_code !== ec || irq_addr !== ea) begin
            n_fail++;
            $display("FAIL %s: got req=%0b code=%b addr=%h, expected req=%0b code=%b addr=%h",
                     tag, irq_req, irq_code, irq_addr, er, ec, ea);
        end
    endtask

    task automatic cfg(logic [1:0] sel, logic [DW-1:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd0) begin b_en = d[3:0]; b_mask = d[19:4]; end
        if (sel == 2'd1) b_lo = d[7:0];
        if (sel == 2'd2) b_hi = d[7:0];
    endtask

    task automatic drive(bit v, logic [7:0] pc, bit br, bit gwe, logic [3:0] gi,
                         bit sv, logic [7:0] sa, int sl);
        ret_valid = v; ret_pc = pc; ret_branch = br; ret_gpr_we = gwe;
        ret_gpr_idx = gi; ret_st_valid = sv; ret_st_addr = sa; ret_st_len = LW'(sl);
    endtask

    task automatic idle();
        drive(0, 8'h0, 0, 0, 4'h0, 0, 8'h0, 0);
    endtask

    task automatic do_ack(string tag);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk(tag, 0, 4'h0, 8'h0);
    endtask

    task automatic run(string tag, bit v, logic [7:0] pc, bit br, bit gwe, logic [3:0] gi,
                       bit sv, logic [7:0] sa, int sl);
        logic [3:0] e;
        e = model(v, pc, br, gwe, gi, sv, sa, sl);
        drive(v, pc, br, gwe, gi, sv, sa, sl);
        @(negedge clk);
        idle();
        chk(tag, e != 0, e, (e != 0) ? pc : 8'h0);
        if (e != 0) do_ack({tag, " ack"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset", 0, 4'h0, 8'h0);
        stat_ext = 1; stat_mon = 1;
        // R1 control word cleared: nothing enabled
        run("R1 disabled after reset", 1, 8'h00, 1, 0, 0, 1, 8'h00, 0);

        // R2 R3 branch enable
        cfg(2'd0, 20'h00001);
        run("R3 branch", 1, 8'h35, 1, 0, 0, 0, 8'h0, 0);
        run("R3 no branch", 1, 8'h36, 0, 0, 0, 0, 8'h0, 0);
        // R10 retire invalid
        run("R10 no retire", 0, 8'h37, 1, 0, 0, 0, 8'h0, 0);

        // R4 register sweep
        cfg(2'd0, {16'hA5C3, 4'b0010});
        for (int i = 0; i < 16; i++) run("R4 gpr", 1, 8'(i + 8'h10), 0, 1, 4'(i), 0, 8'h0, 0);
        run("R4 no write", 1, 8'h20, 0, 0, 4'd0, 0, 8'h0, 0);

        // R5 fetch sweep over three regions
        cfg(2'd0, 20'h00004);
        cfg(2'd1, 20'h40); cfg(2'd2, 20'h7F);
        for (int a = 0; a < 256; a++) run("R5 fetch plain", 1, 8'(a), 0, 0, 0, 0, 8'h0, 0);
        cfg(2'd1, 20'hF0); cfg(2'd2, 20'h0F);
        for (int a = 0; a < 256; a++) run("R5 fetch wrap", 1, 8'(a), 0, 0, 0, 0, 8'h0, 0);
        cfg(2'd1, 20'h80); cfg(2'd2, 20'h80);
        for (int a = 0; a < 256; a++) run("R5 fetch single", 1, 8'(a), 0, 0, 0, 0, 8'h0, 0);

        // R2 select 3 writes nothing: region 0x80..0x80 must survive
        cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 20'h00000;
        @(negedge clk);
        cfg_we = 1'b0;
        run("R2 sel3 ignored", 1, 8'h80, 0, 0, 0, 0, 8'h0, 0);

        // R6 store span sweep
        cfg(2'd0, 20'h00008);
        cfg(2'd1, 20'h40); cfg(2'd2, 20'h7F);
        for (int a = 0; a < 256; a++)
            for (int l = 0; l < MAXB; l++)
                run("R6 store plain", 1, 8'h00, 0, 0, 0, 1, 8'(a), l);
        cfg(2'd1, 20'hFE); cfg(2'd2, 20'h01);
        for (int a = 0; a < 256; a++)
            for (int l = 0; l < MAXB; l++)
                run("R6 store wrap", 1, 8'h80, 0, 0, 0, 1, 8'(a), l);
        run("R6 store not valid", 1, 8'h80, 0, 0, 0, 0, 8'hFE, 3);

        // R7 R8 gate and enable sweep with an instruction hitting all four
        cfg(2'd1, 20'h40); cfg(2'd2, 20'h7F);
        for (int g = 0; g < 4; g++)
            for (int en = 0; en < 16; en++) begin
                stat_ext = g[0]; stat_mon = g[1];
                cfg(2'd0, {16'h0008, 4'(en)});
                run("R7 R8 gates", 1, 8'h50, 1, 1, 4'd3, 1, 8'h3E, 2);
            end

        // R7 dropped events are not reported later
        cfg(2'd0, 20'h0000F);
        stat_ext = 1; stat_mon = 0;
        run("R7 gated off", 1, 8'h44, 1, 0, 0, 0, 8'h0, 0);
        stat_mon = 1;
        @(negedge clk);
        chk("R7 not later", 0, 4'h0, 8'h0);

        // R9 hold while pending, ack collision
        drive(1, 8'h11, 1, 0, 0, 0, 8'h0, 0);
        @(negedge clk);
        drive(1, 8'h22, 0, 1, 4'd3, 0, 8'h0, 0);
        @(negedge clk);
        idle();
        chk("R9 hold", 1, 4'b0001, 8'h11);
        irq_ack = 1'b1;
        drive(1, 8'h33, 1, 0, 0, 0, 8'h0, 0);
        @(negedge clk);
        irq_ack = 1'b0; idle();
        chk("R9 ack capture", 1, 4'b0001, 8'h33);
        do_ack("R9 ack clear");
        @(negedge clk);
        chk("R9 discarded not later", 0, 4'h0, 8'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule